// File: doc/BRIEF.md
# Multi-Channel DMA Register Front End

This block holds the software-visible settings of four DMA channels: a source pointer, a destination pointer, a transfer count and a 16-bit control word for each. Every write passes through that channel's own conditioning rules before it is stored. Address writes are cut to 28 bits with bit 0 cleared and checked against the channel's legal ranges. A count of zero is replaced by the channel's maximum. Control writes lose the bits the channel does not implement.

Each channel runs a two-state machine, `CH_OFF` and `CH_ON`, that follows the enable bit (control bit 15). The transition `CH_OFF -> CH_ON` is called ARM. It happens on a control write that sets enable while the channel is off. On ARM the machine copies the programmed source and destination into working pointers, aligns both down to the transfer unit, and emits a one-cycle arm pulse toward the scheduler together with a misalignment flag. The transition `CH_ON -> CH_OFF` is called DISARM and happens on a control write that clears enable. A control write that keeps enable set in `CH_ON` is called HOLD: it updates the control word and leaves the working pointers alone. The settings of every channel are always visible on flattened output buses. One read port returns the stored control word of a selected channel.

Top module: `dmafe_regfile`

## Requirements
- R1: Writing a count (field select 2, data bits 15:0) stores the value unchanged if it is nonzero. A zero stores 0x4000 on channels 0 to 2 and 0x10000 on channel 3. Reset loads the same maximums.
- R2: Control writes (field select 3) are ANDed with 0xF7E0 on channels 0 to 2 and with 0xFFE0 on channel 3. Bits 4:0 are therefore always zero, and bit 11 is always zero on channels 0 to 2.
- R3: Source writes (field select 0) are reduced to bits 27:0 with bit 0 cleared. The result is stored if it is at least 0x02000000, except that channel 0 also rejects 0x08000000 to 0x0DFFFFFF. A rejected source stores zero.
- R4: Destination writes (field select 1) are reduced in the same way. Channels 0 to 2 accept only results below 0x08000000; channel 3 accepts any. A rejected destination leaves the stored value unchanged.
- R5: On ARM (a control write with bit 15 set while the channel is off), the working source and destination take the stored pointers, aligned down to 2 bytes when control bit 10 is 0 and to 4 bytes when it is 1. The result appears one clock after the write.
- R6: Each ARM produces exactly one single-cycle arm pulse, one clock after the write. A HOLD write produces no pulse and does not change the working pointers. Working pointers change only on ARM.
- R7: The misalignment flag is high with the arm pulse when the 4-byte unit is selected and bit 1 of the stored source or destination was set. It is low in every other cycle.
- R8: The read port returns the stored, masked control word of channel `rd_ch`, combinationally.
- R9: Reset clears addresses, working pointers, control words, pulses and flags, and leaves every channel in `CH_OFF`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_ch | input | 2 | Channel index of the write |
| wr_sel | input | 2 | Field select: 0 source, 1 destination, 2 count, 3 control |
| wr_data | input | 32 | Write data |
| rd_ch | input | 2 | Channel index of the control read |
| rd_ctrl | output | 16 | Stored control word of channel rd_ch |
| cfg_src | output | 112 | Stored source pointers, 28 bits per channel, channel 0 lowest |
| cfg_dst | output | 112 | Stored destination pointers |
| cfg_cnt | output | 68 | Stored counts, 17 bits per channel |
| cfg_ctrl | output | 64 | Stored control words, 16 bits per channel |
| work_src | output | 112 | Working source pointers |
| work_dst | output | 112 | Working destination pointers |
| arm | output | 4 | One-cycle arm pulse per channel |
| misalign | output | 4 | Misalignment flag, valid with arm |

## Verification
The assertions check, on every cycle, the properties that hold for each channel's stored state. The stored count is never zero, and masked control bits never appear. Stored sources and destinations stay inside their legal ranges. An arm pulse lasts one cycle, lines up with enable rising, and captures aligned pointers. Working pointers never move without an ARM. Only the bench's scenarios can show the value mapping of each write. These cases are the zero-count maximum, an illegal source stored as zero, a rejected destination keeping its previous value, and the HOLD write that leaves stale pointers in place. The bench also checks that a DISARM followed by a new ARM reloads the pointers.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;
    localparam int CTRL_W   = 16;
    localparam int BIT_EN   = 15;
    localparam int BIT_WIDE = 10;

    typedef enum logic [1:0] {
        SEL_SRC  = 2'd0,
        SEL_DST  = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        CH_OFF = 1'b0,
        CH_ON  = 1'b1
    } ch_state_e;
endpackage

// File: rtl/dmafe_addr_check.sv
module dmafe_addr_check #(
    parameter int                ADDR_W       = 28,
    parameter bit                RESTRICT_SRC = 1'b0,
    parameter bit                WIDE_DST     = 1'b0,
    parameter logic [ADDR_W-1:0] RAM_BASE     = 28'h200_0000,
    parameter logic [ADDR_W-1:0] ROM_BASE     = 28'h800_0000,
    parameter logic [ADDR_W-1:0] ROM_END      = 28'hE00_0000
) (
    input  logic [ADDR_W-1:0] raw_addr,
    output logic [ADDR_W-1:0] src_value,
    output logic [ADDR_W-1:0] dst_value,
    output logic              dst_ok
);
    logic [ADDR_W-1:0] reduced;
    logic              src_in_rom;
    logic              src_ok;

    always_comb begin
        reduced    = raw_addr & ~ADDR_W'(1);
        src_in_rom = (reduced >= ROM_BASE) && (reduced < ROM_END);
        src_ok     = (reduced >= RAM_BASE) && !(RESTRICT_SRC && src_in_rom);
        src_value  = src_ok ? reduced : '0;
        dst_value  = reduced;
        dst_ok     = WIDE_DST || (reduced < ROM_BASE);
    end
endmodule

// File: rtl/dmafe_field_cond.sv
module dmafe_field_cond #(
    parameter int                CNT_W     = 17,
    parameter logic [CNT_W-1:0]  MAX_COUNT = 17'h4000,
    parameter logic [15:0]       CTRL_MASK = 16'hF7E0
) (
    input  logic [15:0]      raw_half,
    output logic [CNT_W-1:0] cnt_value,
    output logic [15:0]      ctrl_value
);
    always_comb begin
        cnt_value  = (raw_half == 16'h0) ? MAX_COUNT : CNT_W'(raw_half);
        ctrl_value = raw_half & CTRL_MASK;
    end
endmodule

// File: rtl/dmafe_channel.sv
module dmafe_channel
    import dmafe_pkg::*;
#(
    parameter int                ADDR_W    = 28,
    parameter int                CNT_W     = 17,
    parameter bit                RESTRICT  = 1'b0,
    parameter bit                WIDE      = 1'b0,
    parameter logic [CNT_W-1:0]  MAX_CNT   = 17'h4000,
    parameter logic [15:0]       CTRL_MASK = 16'hF7E0,
    parameter logic [ADDR_W-1:0] RAM_BASE  = 28'h200_0000,
    parameter logic [ADDR_W-1:0] ROM_BASE  = 28'h800_0000,
    parameter logic [ADDR_W-1:0] ROM_END   = 28'hE00_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [1:0]        wr_sel,
    input  logic [31:0]       wr_data,
    output logic [ADDR_W-1:0] src_o,
    output logic [ADDR_W-1:0] dst_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic [ADDR_W-1:0] wsrc_o,
    output logic [ADDR_W-1:0] wdst_o,
    output logic              arm_o,
    output logic              mis_o
);
    logic [ADDR_W-1:0] src_q, dst_q, wsrc_q, wdst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic              arm_q, mis_q;
    ch_state_e         state_q, state_d;

    logic [ADDR_W-1:0] src_new, dst_new, align_mask;
    logic              dst_ok, arm_ev;
    logic [CNT_W-1:0]  cnt_new;
    logic [CTRL_W-1:0] ctrl_new;
    logic              ctrl_wr;
    logic              unused_hi;

    assign unused_hi = ^wr_data[31:ADDR_W];

    dmafe_addr_check #(
        .ADDR_W(ADDR_W), .RESTRICT_SRC(RESTRICT), .WIDE_DST(WIDE),
        .RAM_BASE(RAM_BASE), .ROM_BASE(ROM_BASE), .ROM_END(ROM_END)
    ) addr_chk_i (
        .raw_addr (wr_data[ADDR_W-1:0]),
        .src_value(src_new),
        .dst_value(dst_new),
        .dst_ok   (dst_ok)
    );

    dmafe_field_cond #(
        .CNT_W(CNT_W), .MAX_COUNT(MAX_CNT), .CTRL_MASK(CTRL_MASK)
    ) field_i (
        .raw_half  (wr_data[15:0]),
        .cnt_value (cnt_new),
        .ctrl_value(ctrl_new)
    );

    assign ctrl_wr    = wr_hit && (wr_sel == SEL_CTRL);
    assign align_mask = ctrl_new[BIT_WIDE] ? ~ADDR_W'(3) : ~ADDR_W'(1);

    // Next-state logic: ARM, DISARM, HOLD
    always_comb begin
        state_d = state_q;
        arm_ev  = 1'b0;
        unique case (state_q)
            CH_OFF: if (ctrl_wr && ctrl_new[BIT_EN]) begin
                state_d = CH_ON;
                arm_ev  = 1'b1;
            end
            CH_ON: if (ctrl_wr && !ctrl_new[BIT_EN]) begin
                state_d = CH_OFF;
            end
            default: state_d = CH_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // Programmed registers and ARM outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= MAX_CNT;
            ctrl_q <= '0;
            wsrc_q <= '0;
            wdst_q <= '0;
            arm_q  <= 1'b0;
            mis_q  <= 1'b0;
        end else begin
            arm_q <= arm_ev;
            mis_q <= arm_ev && (|((src_q | dst_q) & ~align_mask));
            if (arm_ev) begin
                wsrc_q <= src_q & align_mask;
                wdst_q <= dst_q & align_mask;
            end
            if (wr_hit) begin
                unique case (wr_sel)
                    SEL_SRC:  src_q <= src_new;
                    SEL_DST:  if (dst_ok) dst_q <= dst_new;
                    SEL_CNT:  cnt_q <= cnt_new;
                    SEL_CTRL: ctrl_q <= ctrl_new;
                    default:  ;
                endcase
            end
        end
    end

    assign src_o  = src_q;
    assign dst_o  = dst_q;
    assign cnt_o  = cnt_q;
    assign ctrl_o = ctrl_q;
    assign wsrc_o = wsrc_q;
    assign wdst_o = wdst_q;
    assign arm_o  = arm_q;
    assign mis_o  = mis_q;

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0) else $error("count zero"); // R1
    AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_MASK) == '0) else $error("masked bits set"); // R2
    AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == '0) || ((src_q >= RAM_BASE) && !src_q[0] &&
        !(RESTRICT && src_q >= ROM_BASE && src_q < ROM_END))) else $error("illegal src"); // R3
    AST_DST_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !dst_q[0] && (WIDE || dst_q < ROM_BASE)) else $error("illegal dst"); // R4
    AST_ARM_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> (!wsrc_q[0] && !wdst_q[0] &&
        (!ctrl_q[BIT_WIDE] || (wsrc_q[1:0] == 2'b00 && wdst_q[1:0] == 2'b00)))) else $error("unaligned"); // R5
    AST_ARM_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |=> !arm_q) else $error("long arm"); // R6
    AST_ARM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        arm_q |-> ($rose(ctrl_q[BIT_EN]) && state_q == CH_ON)) else $error("arm w/o rise"); // R6
    AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !arm_q |-> ($stable(wsrc_q) && $stable(wdst_q))) else $error("work moved"); // R6
    AST_MIS_WITH_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        mis_q |-> (arm_q && ctrl_q[BIT_WIDE])) else $error("stray misalign"); // R7
endmodule

// File: rtl/dmafe_regfile.sv
module dmafe_regfile
    import dmafe_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 28,
    parameter int CNT_W  = 17,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [CH_W-1:0]          wr_ch,
    input  logic [1:0]               wr_sel,
    input  logic [31:0]              wr_data,
    input  logic [CH_W-1:0]          rd_ch,
    output logic [CTRL_W-1:0]        rd_ctrl,
    output logic [NUM_CH*ADDR_W-1:0] cfg_src,
    output logic [NUM_CH*ADDR_W-1:0] cfg_dst,
    output logic [NUM_CH*CNT_W-1:0]  cfg_cnt,
    output logic [NUM_CH*CTRL_W-1:0] cfg_ctrl,
    output logic [NUM_CH*ADDR_W-1:0] work_src,
    output logic [NUM_CH*ADDR_W-1:0] work_dst,
    output logic [NUM_CH-1:0]        arm,
    output logic [NUM_CH-1:0]        misalign
);
    localparam logic [CNT_W-1:0]  CNT_FULL  = CNT_W'(32'h1_0000);
    localparam logic [CNT_W-1:0]  CNT_PART  = CNT_W'(32'h4000);
    localparam logic [15:0]       MASK_FULL = 16'hFFE0;
    localparam logic [15:0]       MASK_PART = 16'hF7E0;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam bit IS_WIDE = (g == NUM_CH - 1);
        localparam bit IS_RSTR = (g == 0);

        dmafe_channel #(
            .ADDR_W   (ADDR_W),
            .CNT_W    (CNT_W),
            .RESTRICT (IS_RSTR),
            .WIDE     (IS_WIDE),
            .MAX_CNT  (IS_WIDE ? CNT_FULL : CNT_PART),
            .CTRL_MASK(IS_WIDE ? MASK_FULL : MASK_PART)
        ) ch_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_en && (wr_ch == CH_W'(g))),
            .wr_sel (wr_sel),
            .wr_data(wr_data),
            .src_o  (cfg_src[g*ADDR_W +: ADDR_W]),
            .dst_o  (cfg_dst[g*ADDR_W +: ADDR_W]),
            .cnt_o  (cfg_cnt[g*CNT_W +: CNT_W]),
            .ctrl_o (cfg_ctrl[g*CTRL_W +: CTRL_W]),
            .wsrc_o (work_src[g*ADDR_W +: ADDR_W]),
            .wdst_o (work_dst[g*ADDR_W +: ADDR_W]),
            .arm_o  (arm[g]),
            .mis_o  (misalign[g])
        );
    end

    assign rd_ctrl = cfg_ctrl[rd_ch*CTRL_W +: CTRL_W];

    AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl[4:0] == 5'b0) else $error("read low bits"); // R8
    AST_ARM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (arm & ~{cfg_ctrl[3*CTRL_W+15], cfg_ctrl[2*CTRL_W+15],
                 cfg_ctrl[CTRL_W+15], cfg_ctrl[15]}) == '0) else $error("arm while off"); // R9
endmodule

// File: tb/dmafe_regfile_tb.sv
module dmafe_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_ch = '0, wr_sel = '0, rd_ch = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] rd_ctrl;
    logic [111:0] cfg_src, cfg_dst, work_src, work_dst;
    logic [67:0] cfg_cnt;
    logic [63:0] cfg_ctrl;
    logic [3:0]  arm, misalign;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    int unsigned m_src[4], m_dst[4], m_cnt[4], m_ctrl[4], m_ws[4], m_wd[4];
    bit m_arm[4], m_mis[4];

    always #5 clk = ~clk;

    dmafe_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_ch(rd_ch), .rd_ctrl(rd_ctrl),
        .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt), .cfg_ctrl(cfg_ctrl),
        .work_src(work_src), .work_dst(work_dst), .arm(arm), .misalign(misalign)
    );

    function automatic void model_reset();
        for (int c = 0; c < 4; c++) begin
            m_src[c] = 0; m_dst[c] = 0; m_ctrl[c] = 0; m_ws[c] = 0; m_wd[c] = 0;
            m_cnt[c] = (c == 3) ? 32'h1_0000 : 32'h4000;
            m_arm[c] = 0; m_mis[c] = 0;
        end
    endfunction

    function automatic void model_write(int c, int s, int unsigned d);
        int unsigned a = d & 32'h0FFF_FFFE;
        int unsigned k, al;
        case (s)
            0: begin
                if (a < 32'h0200_0000 || (c == 0 && a >= 32'h0800_0000 && a < 32'h0E00_0000))
                    m_src[c] = 0;
                else m_src[c] = a;
            end
            1: if (c == 3 || a < 32'h0800_0000) m_dst[c] = a;
            2: m_cnt[c] = ((d & 32'hFFFF) == 0) ? ((c == 3) ? 32'h1_0000 : 32'h4000) : (d & 32'hFFFF);
            default: begin
                k = d & ((c == 3) ? 32'hFFE0 : 32'hF7E0);
                if (m_ctrl[c][15] == 1'b0 && k[15]) begin
                    al = k[10] ? 32'hFFFF_FFFC : 32'hFFFF_FFFE;
                    m_arm[c] = 1;
                    m_mis[c] = k[10] && (((m_src[c] | m_dst[c]) & 3) != 0);
                    m_ws[c] = m_src[c] & al;
                    m_wd[c] = m_dst[c] & al;
                end
                m_ctrl[c] = k;
            end
        endcase
    endfunction

    initial model_reset();

    always @(posedge clk) begin
        for (int c = 0; c < 4; c++) begin m_arm[c] = 0; m_mis[c] = 0; end
        if (!rst_n) model_reset();
        else if (wr_en) model_write(wr_ch, wr_sel, wr_data);
    end

    task automatic chk(string req, int c, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d: actual %h expected %h at %0t", req, c, act, exp, $time);
        end
    endtask

    always @(negedge clk) if (!done) begin
        for (int c = 0; c < 4; c++) begin
            chk("R3 src", c, 32'(cfg_src[c*28 +: 28]), m_src[c]);
            chk("R4 dst", c, 32'(cfg_dst[c*28 +: 28]), m_dst[c]);
            chk("R1 count", c, 32'(cfg_cnt[c*17 +: 17]), m_cnt[c]);
            chk("R2 ctrl", c, 32'(cfg_ctrl[c*16 +: 16]), m_ctrl[c]);
            chk("R5 work_src", c, 32'(work_src[c*28 +: 28]), m_ws[c]);
            chk("R5 work_dst", c, 32'(work_dst[c*28 +: 28]), m_wd[c]);
            chk("R6 arm", c, 32'(arm[c]), 32'(m_arm[c]));
            chk("R7 misalign", c, 32'(misalign[c]), 32'(m_mis[c]));
        end
        chk("R8 read", int'(rd_ch), 32'(rd_ctrl), m_ctrl[rd_ch]);
    end

    task automatic wr(int c, int s, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(c); wr_sel = 2'(s); wr_data = d;
        rd_ch = rd_ch + 2'd1;
        @(negedge clk);
        wr_en = 1'b0;
        rd_ch = 2'(c);
    endtask

    initial begin
        fork
            begin
                #200000;
                n_chk++; n_fail++;
                $display("FAIL watchdog expired");
                done = 1'b1;
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        join_none
        repeat (3) @(negedge clk);   // R9 reset state checked every negedge
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        wr(0, 2, 32'h0); wr(3, 2, 32'h0); wr(1, 2, 32'h0123);          // R1
        wr(0, 3, 32'h7FFF); wr(3, 3, 32'h7FFF);                        // R2
        wr(1, 0, 32'h01FF_FFFE); wr(0, 0, 32'h0800_1000);              // R3 illegal
        wr(1, 0, 32'h0800_1000); wr(2, 0, 32'hF200_0003);              // R3 legal
        wr(1, 1, 32'h0300_0000); wr(1, 1, 32'h0900_0000);              // R4 rejected keeps
        wr(3, 1, 32'h0900_0000);                                       // R4 wide channel
        wr(2, 0, 32'h0200_0006); wr(2, 1, 32'h0300_0010);
        wr(2, 3, 32'h8400);                                            // R5 R7 arm 4-byte
        wr(2, 0, 32'h0200_0100); wr(2, 3, 32'h8000);                   // R6 hold no reload
        wr(2, 3, 32'h0000); wr(2, 3, 32'h8000);                        // R6 rearm reloads
        wr(3, 0, 32'h0200_0002); wr(3, 3, 32'hFFFF);                   // R2 R5 R7 ch3
        wr(0, 3, 32'h8000);                                            // R5 ch0 zero src
        wr(1, 3, 32'h8400);                                            // R7 aligned 4-byte
        rst_n = 1'b0;                                                  // R9 reset again
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule